// File: doc/BRIEF.md
# SD Card Host Bring-Up Sequencer

This block is the host-side controller that takes an SD memory card from power-up to the data-transfer state. It does not serialize commands itself. It hands a command index, an argument and an application-command flag to a separate command/response engine. It then waits for that engine to report either a response or a timeout. Commands go out in a fixed order:

- a clock warm-up with CMD held high;
- a reset command;
- operating-condition negotiation with busy polling;
- identification and address assignment;
- selection and a card-type check;
- a deselect/reselect pass that reads the card-specific data and identification again;
- the bus-width setting.

The sequencer gates the SD clock and the idle level of the CMD line. DAT3 stays pulled high, so the card remains in SD mode. Every application command is preceded by CMD55, which carries the current relative address. That address is zero until the card has assigned one.

When the sequence ends, the block raises either a done flag or an error code. It also returns to idle and waits for the next start request. The negotiated OCR, the capacity bit, the relative address and the 128-bit identification and card-specific registers stay visible on the outputs. The retry budget for busy polling is an input, and the voltage window offered to the card is a parameter.

Top module: `sd_init_seq`

## Requirements
- R1: After `start_i`, `sdclk_en_o` and `cmd_hi_o` are high for exactly WARMUP_CLKS cycles (default 80, which is at least 74) before the first `cmd_start_o`. The first command is index 0 with argument 0.
- R2: Every application command is issued as index 55 with argument {RCA,16'h0}, followed by the target command with `cmd_app_o`=1. `cmd_app_o` is 0 on every other command. A CMD55 response that times out or has bit 5 clear ends the sequence with error code 5.
- R3: The first index-41 command carries argument 0. Every later one carries {8'h40, window & VDD_MASK}, where window is bits [23:0] of the first response. The command repeats until a response has bit 31 set.
- R4: A timeout on any index-41 command ends the sequence with error code 1.
- R5: `retry_limit_i`=L permits at most L busy index-41 poll responses (L=0 acts as 1). The L-th busy response ends the sequence with error code 2.
- R6: After power-up completes, the commands follow this order:
  - index 2 (arg 0), then index 3 (arg 0);
  - index 7 with {RCA,16'h0};
  - index 42 with arg 0, only when `cd_off_i` was high at start;
  - index 13;
  - index 7 with arg 0;
  - index 9, index 10 and index 7, each with {RCA,16'h0};
  - index 6 with arg 2 when `wide_i` was high at start, else 0.
- R7: The RCA is taken from response bits [31:16] of index 3. A zero value ends the sequence with error code 3.
- R8: For index 13, response bits [15:8] (the upper card-type byte) must be zero, else the sequence ends with error code 4. Bits [7:0] are ignored.
- R9: A timeout on any command other than index 41 or CMD55 ends the sequence with error code 6.
- R10: After the index-6 response, `done_o` goes high. At that point:
  - `ocr_o` holds the last index-41 response, with bit 31 set;
  - `ccs_o` equals its bit 30;
  - `csd_o` holds the index-9 response;
  - `cid_o` holds the index-10 response.
- R11: After reset, and after any error, the block sits idle with `sdclk_en_o`, `cmd_hi_o` and `cmd_start_o` low and issues nothing until `start_i`. `err_o` and `err_code_o` hold until the next start, which clears them. `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one SD clock per cycle while enabled |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up sequence (accepted when idle) |
| retry_limit_i | input | RETRY_W | Maximum busy responses to ACMD41 polls |
| cd_off_i | input | 1 | Send the card-detect pull-up disconnect command |
| wide_i | input | 1 | Request 4-bit bus width |
| cmd_start_o | output | 1 | One-cycle command issue strobe |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_app_o | output | 1 | Command is the target of an application command |
| rsp_valid_i | input | 1 | Response received |
| rsp_timeout_i | input | 1 | No response within the engine's window |
| rsp_data_i | input | RSP_W | Response payload, short responses in [31:0] |
| sdclk_en_o | output | 1 | SD clock enable |
| cmd_hi_o | output | 1 | Drive CMD idle level high |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sequence aborted |
| err_code_o | output | 3 | Abort reason |
| rca_o | output | 16 | Captured relative card address |
| ocr_o | output | 32 | Last operating-conditions response |
| ccs_o | output | 1 | Card capacity status |
| cid_o | output | RSP_W | Identification register |
| csd_o | output | RSP_W | Card-specific data register |

## Verification
The hardest case to reach is the boundary between busy polling and the retry budget. Whether the sequence succeeds or aborts depends on how many busy responses the card gives compared with the limit, and that count can only be shaped through the response port. The bench model of the card engine is therefore scripted with a busy count. It is swept together with the retry limit over a small grid, and the expected poll count and outcome are computed arithmetically for each pair. Each abort path is also reached by scripting a single fault into the engine model: a timeout on a chosen index, a zero address, a non-zero type byte, or a missing application flag.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WARM, S_GO_IDLE, S_OP_QUERY, S_OP_POLL, S_GET_CID, S_GET_RCA,
    S_SEL1, S_CD_OFF, S_STATUS, S_DESEL, S_GET_CSD, S_GET_CID2, S_SEL2, S_WIDTH
  } step_e;

  typedef enum logic [1:0] {PH_APP, PH_APP_WAIT, PH_CMD, PH_CMD_WAIT} phase_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_NOT_SD = 3'd1, E_RETRY = 3'd2, E_RCA0 = 3'd3,
    E_TYPE = 3'd4, E_APP = 3'd5, E_TIMEOUT = 3'd6
  } err_e;

  localparam logic [5:0] APP_PREFIX = 6'd55;
  localparam int unsigned APP_STAT_BIT = 5;

  function automatic logic is_app(step_e s);
    return s inside {S_OP_QUERY, S_OP_POLL, S_CD_OFF, S_STATUS, S_WIDTH};
  endfunction

endpackage

// File: rtl/sd_init_warmup.sv
module sd_init_warmup #(
  parameter int unsigned CLKS = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sd_init_poll.sv
module sd_init_poll #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         busy_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (busy_i)  cnt_q <= cnt_q + 1'b1;
  end

  // this busy response exhausts the budget
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
endmodule

// File: rtl/sd_init_cmdgen.sv
module sd_init_cmdgen
  import sd_init_pkg::*;
#(
  parameter logic [23:0] VDD_MASK = 24'hFF8000
) (
  input  step_e        step_i,
  input  logic [15:0]  rca_i,
  input  logic [23:0]  win_i,
  input  logic         wide_i,
  output logic [5:0]   idx_o,
  output logic [31:0]  arg_o
);
  logic [31:0] addr_arg;
  assign addr_arg = {rca_i, 16'h0};

  always_comb begin
    idx_o = 6'd0;
    arg_o = 32'h0;
    unique case (step_i)
      S_OP_QUERY: idx_o = 6'd41;
      S_OP_POLL:  begin idx_o = 6'd41; arg_o = {8'h40, win_i & VDD_MASK}; end
      S_GET_CID:  idx_o = 6'd2;
      S_GET_RCA:  idx_o = 6'd3;
      S_SEL1,
      S_SEL2:     begin idx_o = 6'd7;  arg_o = addr_arg; end
      S_CD_OFF:   idx_o = 6'd42;
      S_STATUS:   idx_o = 6'd13;
      S_DESEL:    idx_o = 6'd7;
      S_GET_CSD:  begin idx_o = 6'd9;  arg_o = addr_arg; end
      S_GET_CID2: begin idx_o = 6'd10; arg_o = addr_arg; end
      S_WIDTH:    begin idx_o = 6'd6;  arg_o = wide_i ? 32'd2 : 32'd0; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int unsigned WARMUP_CLKS = 80,
  parameter int unsigned RETRY_W     = 8,
  parameter int unsigned RSP_W       = 128,
  parameter logic [23:0] VDD_MASK    = 24'hFF8000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  input  logic               cd_off_i,
  input  logic               wide_i,
  output logic               cmd_start_o,
  output logic [5:0]         cmd_idx_o,
  output logic [31:0]        cmd_arg_o,
  output logic               cmd_app_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_timeout_i,
  input  logic [RSP_W-1:0]   rsp_data_i,
  output logic               sdclk_en_o,
  output logic               cmd_hi_o,
  output logic               done_o,
  output logic               err_o,
  output logic [2:0]         err_code_o,
  output logic [15:0]        rca_o,
  output logic [31:0]        ocr_o,
  output logic               ccs_o,
  output logic [RSP_W-1:0]   cid_o,
  output logic [RSP_W-1:0]   csd_o
);
  step_e             st_q;
  phase_e            ph_q;
  err_e              err_q;
  logic              done_q, cd_q, wide_q, ccs_q;
  logic [15:0]       rca_q;
  logic [31:0]       ocr_q;
  logic [23:0]       win_q;
  logic [RSP_W-1:0]  cid_q, csd_q;
  logic              warm_done, poll_last, poll_busy, active, issuing;
  logic [5:0]        gen_idx;
  logic [31:0]       gen_arg;
  step_e             nxt;

  sd_init_warmup #(.CLKS(WARMUP_CLKS)) u_warm (
    .clk_i, .rst_ni, .run_i(st_q == S_WARM), .done_o(warm_done)
  );

  assign poll_busy = (st_q == S_OP_POLL) && (ph_q == PH_CMD_WAIT) &&
                     rsp_valid_i && !rsp_timeout_i && !rsp_data_i[31];

  sd_init_poll #(.W(RETRY_W)) u_poll (
    .clk_i, .rst_ni, .clr_i(st_q == S_WARM), .busy_i(poll_busy),
    .limit_i(retry_limit_i), .last_o(poll_last)
  );

  sd_init_cmdgen #(.VDD_MASK(VDD_MASK)) u_gen (
    .step_i(st_q), .rca_i(rca_q), .win_i(win_q), .wide_i(wide_q),
    .idx_o(gen_idx), .arg_o(gen_arg)
  );

  always_comb begin
    unique case (st_q)
      S_GO_IDLE:  nxt = S_OP_QUERY;
      S_OP_QUERY: nxt = S_OP_POLL;
      S_OP_POLL:  nxt = S_GET_CID;
      S_GET_CID:  nxt = S_GET_RCA;
      S_GET_RCA:  nxt = S_SEL1;
      S_SEL1:     nxt = cd_q ? S_CD_OFF : S_STATUS;
      S_CD_OFF:   nxt = S_STATUS;
      S_STATUS:   nxt = S_DESEL;
      S_DESEL:    nxt = S_GET_CSD;
      S_GET_CSD:  nxt = S_GET_CID2;
      S_GET_CID2: nxt = S_SEL2;
      S_SEL2:     nxt = S_WIDTH;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  ph_q <= PH_CMD;  err_q <= E_NONE;  done_q <= 1'b0;
      cd_q <= 1'b0;    wide_q <= 1'b0;  ccs_q <= 1'b0;    rca_q <= '0;
      ocr_q <= '0;     win_q <= '0;     cid_q <= '0;      csd_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q <= S_WARM;  err_q <= E_NONE;  done_q <= 1'b0;  ccs_q <= 1'b0;
          rca_q <= '0;     ocr_q <= '0;      cd_q <= cd_off_i; wide_q <= wide_i;
        end
        S_WARM: if (warm_done) begin
          st_q <= S_GO_IDLE;  ph_q <= PH_CMD;
        end
        default: begin
          unique case (ph_q)
            PH_APP: ph_q <= PH_APP_WAIT;
            PH_CMD: ph_q <= PH_CMD_WAIT;
            PH_APP_WAIT: begin
              if (rsp_timeout_i || (rsp_valid_i && !rsp_data_i[APP_STAT_BIT])) begin
                err_q <= E_APP;  st_q <= S_IDLE;
              end else if (rsp_valid_i) ph_q <= PH_CMD;
            end
            PH_CMD_WAIT: begin
              if (rsp_timeout_i) begin
                err_q <= (st_q inside {S_OP_QUERY, S_OP_POLL}) ? E_NOT_SD : E_TIMEOUT;
                st_q  <= S_IDLE;
              end else if (rsp_valid_i) begin
                st_q <= nxt;
                ph_q <= is_app(nxt) ? PH_APP : PH_CMD;
                unique case (st_q)
                  S_OP_QUERY: begin ocr_q <= rsp_data_i[31:0]; win_q <= rsp_data_i[23:0]; end
                  S_OP_POLL: begin
                    ocr_q <= rsp_data_i[31:0];
                    if (rsp_data_i[31]) ccs_q <= rsp_data_i[30];
                    else if (poll_last) begin err_q <= E_RETRY; st_q <= S_IDLE; end
                    else begin st_q <= S_OP_POLL; ph_q <= PH_APP; end
                  end
                  S_GET_CID, S_GET_CID2: cid_q <= rsp_data_i;
                  S_GET_CSD: csd_q <= rsp_data_i;
                  S_GET_RCA:
                    if (rsp_data_i[31:16] == 16'h0) begin err_q <= E_RCA0; st_q <= S_IDLE; end
                    else rca_q <= rsp_data_i[31:16];
                  S_STATUS:
                    if (rsp_data_i[15:8] != 8'h0) begin err_q <= E_TYPE; st_q <= S_IDLE; end
                  S_WIDTH: done_q <= 1'b1;
                  default: ;
                endcase
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assign active      = (st_q != S_IDLE);
  assign issuing     = active && (st_q != S_WARM) && (ph_q inside {PH_APP, PH_CMD});
  assign cmd_start_o = issuing;
  assign cmd_idx_o   = (ph_q == PH_APP) ? APP_PREFIX : gen_idx;
  assign cmd_arg_o   = (ph_q == PH_APP) ? {rca_q, 16'h0} : gen_arg;
  assign cmd_app_o   = issuing && (ph_q == PH_CMD) && is_app(st_q);
  assign sdclk_en_o  = active || done_q;
  assign cmd_hi_o    = active || done_q;
  assign done_o      = done_q;
  assign err_o       = (err_q != E_NONE);
  assign err_code_o  = err_q;
  assign rca_o       = rca_q;
  assign ocr_o       = ocr_q;
  assign ccs_o       = ccs_q;
  assign cid_o       = cid_q;
  assign csd_o       = csd_q;
endmodule

// File: rtl/sd_init_chk.sv
module sd_init_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_start_o,
  input logic [5:0]  cmd_idx_o,
  input logic        cmd_app_o,
  input logic        sdclk_en_o,
  input logic        cmd_hi_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rca_o,
  input logic [31:0] ocr_o,
  input logic        ccs_o
);
  logic [5:0] last_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_idx_q <= '0;
    else if (cmd_start_o) last_idx_q <= cmd_idx_o;
  end

  a_r1_clock_before_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |-> sdclk_en_o && cmd_hi_o);
  a_r2_app_after_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && cmd_app_o) |-> last_idx_q == 6'd55);
  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |=> !cmd_start_o);
  a_r7_rca_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rca_o != 16'h0);
  a_r10_ready_ocr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ocr_o[31] && (ccs_o == ocr_o[30]));
  a_r11_quiet_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !cmd_start_o && !sdclk_en_o);
  a_r11_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

bind sd_init_seq sd_init_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_start_o(cmd_start_o), .cmd_idx_o(cmd_idx_o),
  .cmd_app_o(cmd_app_o), .sdclk_en_o(sdclk_en_o), .cmd_hi_o(cmd_hi_o),
  .done_o(done_o), .err_o(err_o), .rca_o(rca_o), .ocr_o(ocr_o), .ccs_o(ccs_o)
);

// File: tb/tb_sd_init_seq.sv
module tb_sd_init_seq;
  localparam int PERIOD = 10;
  localparam int WARM = 80;
  localparam logic [23:0] WIN = 24'hFF8000;
  localparam logic [31:0] ARG41 = {8'h40, WIN};
  localparam logic [127:0] CID1 = 128'hC1D1_0000_1111_2222_3333_4444_5555_6601;
  localparam logic [127:0] CID2 = 128'hC1D2_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0001;
  localparam logic [127:0] CSDV = 128'h400E_0032_5B59_0000_EDC8_7F80_0A40_0001;

  logic clk = 0, rst_n = 0, start = 0, cd_off = 0, wide = 0;
  logic [7:0] limit = 8'd8;
  logic cmd_start, cmd_app, rsp_valid = 0, rsp_to = 0;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg, ocr;
  logic [127:0] rsp_data = '0, cid, csd;
  logic sdclk_en, cmd_hi, done, err, ccs;
  logic [2:0] err_code;
  logic [15:0] rca;

  always #(PERIOD/2) clk = ~clk;

  sd_init_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .retry_limit_i(limit),
    .cd_off_i(cd_off), .wide_i(wide), .cmd_start_o(cmd_start), .cmd_idx_o(cmd_idx),
    .cmd_arg_o(cmd_arg), .cmd_app_o(cmd_app), .rsp_valid_i(rsp_valid),
    .rsp_timeout_i(rsp_to), .rsp_data_i(rsp_data), .sdclk_en_o(sdclk_en),
    .cmd_hi_o(cmd_hi), .done_o(done), .err_o(err), .err_code_o(err_code),
    .rca_o(rca), .ocr_o(ocr), .ccs_o(ccs), .cid_o(cid), .csd_o(csd)
  );

  // scripted card engine
  int cfg_busy = 0, cfg_to = 99;
  logic cfg_ccs = 0, cfg_app_ok = 1;
  logic [15:0] cfg_rca = 16'h1234, cfg_type = 16'h0;
  int log_idx [64];
  logic [31:0] log_arg [64];
  logic log_app [64];
  int n_log = 0, busy_left = 0, warm_cnt = 0, dly = 0, p_idx = 0;
  logic started = 0, pend = 0;
  logic [31:0] p_arg = 0;

  always @(negedge clk) begin
    rsp_valid = 0; rsp_to = 0;
    if (!sdclk_en) begin warm_cnt = 0; started = 0; end
    else if (!started && cmd_hi && !cmd_start) warm_cnt++;
    if (pend) begin
      if (dly == 0) begin
        pend = 0;
        rsp_data = '0;
        if (p_idx == cfg_to) rsp_to = 1;
        else begin
          rsp_valid = 1;
          case (p_idx)
            55: rsp_data[31:0] = cfg_app_ok ? 32'h120 : 32'h100;
            41: if (p_arg == 0 || busy_left > 0) begin
                  if (p_arg != 0) busy_left--;
                  rsp_data[31:0] = {8'h00, WIN};
                end else rsp_data[31:0] = {1'b1, cfg_ccs, 6'b0, WIN};
            2:  rsp_data = CID1;
            3:  rsp_data[31:0] = {cfg_rca, 16'h0520};
            13: rsp_data[31:0] = {16'h0, cfg_type};
            9:  rsp_data = CSDV;
            10: rsp_data = CID2;
            default: rsp_data[31:0] = 32'h0900;
          endcase
        end
      end else dly--;
    end
    if (cmd_start) begin
      started = 1;
      if (cmd_idx == 0) begin n_log = 0; busy_left = cfg_busy; end
      if (n_log < 64) begin
        log_idx[n_log] = int'(cmd_idx); log_arg[n_log] = cmd_arg; log_app[n_log] = cmd_app;
        n_log++;
      end
      pend = 1; dly = 2; p_idx = int'(cmd_idx); p_arg = cmd_arg;
    end
  end

  int checks = 0, errors = 0;
  int e_idx [64];
  logic [31:0] e_arg [64];
  logic e_app [64];
  int ne = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add(input int i, input logic [31:0] a, input logic ap);
    e_idx[ne] = i; e_arg[ne] = a; e_app[ne] = ap; ne++;
  endtask

  task automatic build_exp(input int b, input logic cdo, input logic wd, input logic [15:0] r);
    logic [31:0] ra;
    ra = {r, 16'h0};
    ne = 0;
    add(0, 0, 0); add(55, 0, 0); add(41, 0, 1);
    for (int i = 0; i <= b; i++) begin add(55, 0, 0); add(41, ARG41, 1); end
    add(2, 0, 0); add(3, 0, 0); add(7, ra, 0);
    if (cdo) begin add(55, ra, 0); add(42, 0, 1); end
    add(55, ra, 0); add(13, 0, 1); add(7, 0, 0);
    add(9, ra, 0); add(10, ra, 0); add(7, ra, 0);
    add(55, ra, 0); add(6, wd ? 32'd2 : 32'd0, 1);
  endtask

  task automatic cmp_seq(input string req);
    int bad;
    bad = (n_log != ne) ? 0 : -1;
    for (int i = 0; i < ne && bad < 0; i++)
      if (log_idx[i] != e_idx[i] || log_arg[i] != e_arg[i] || log_app[i] != e_app[i]) bad = i;
    if (bad < 0) chk(1, req, "sequence", 0, 0);
    else if (n_log != ne) chk(0, req, "sequence length", n_log, ne);
    else chk(0, req, $sformatf("entry %0d idx/arg/app", bad),
             {log_idx[bad][7:0], log_arg[bad], 7'b0, log_app[bad]},
             {e_idx[bad][7:0], e_arg[bad], 7'b0, e_app[bad]});
  endtask

  function automatic int count41();
    int c = 0;
    for (int i = 0; i < n_log; i++) if (log_idx[i] == 41) c++;
    return c;
  endfunction

  task automatic run(output bit ended);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    ended = 0;
    for (int i = 0; i < 5000 && !ended; i++) begin
      @(negedge clk);
      if (done || err) ended = 1;
    end
    chk(ended, "R11", "sequence ended", 0, 1);
  endtask

  task automatic setup(input int b, input int l, input logic c, input logic [15:0] r,
                       input logic [15:0] t, input logic ao, input int to,
                       input logic cdo, input logic wd);
    cfg_busy = b; limit = 8'(l); cfg_ccs = c; cfg_rca = r; cfg_type = t;
    cfg_app_ok = ao; cfg_to = to; cd_off = cdo; wide = wd;
  endtask

  task automatic expect_err(input int code, input string req);
    int n0;
    chk(err && !done && err_code == 3'(code), req, "error code", {err, err_code}, {1'b1, 3'(code)});
    n0 = n_log;
    repeat (20) @(negedge clk);
    chk(n_log == n0 && !sdclk_en && !cmd_hi && err, "R11", "quiet after error",
        {n_log[7:0], sdclk_en, cmd_hi, err}, {n0[7:0], 3'b001});
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ended;
    repeat (3) @(negedge clk);
    chk(!done && !err && !sdclk_en && !cmd_hi && !cmd_start, "R11", "reset state",
        {done, err, sdclk_en, cmd_hi, cmd_start}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R3 R6 R8 R10: main flow, type low byte nonzero is ignored
    setup(2, 8, 1, 16'h1234, 16'h00FF, 1, 99, 1, 1);
    run(ended);
    chk(warm_cnt == WARM, "R1", "warm-up cycles", warm_cnt, WARM);
    chk(log_idx[0] == 0 && log_arg[0] == 0, "R1", "first command", log_idx[0], 0);
    build_exp(2, 1, 1, 16'h1234);
    cmp_seq("R6");
    chk(done && !err, "R8", "done with low type bits set", {done, err}, 2'b10);
    chk(ocr == {2'b11, 6'b0, WIN} && ccs, "R10", "ocr/ccs", {ccs, ocr}, {1'b1, 2'b11, 6'b0, WIN});
    chk(rca == 16'h1234, "R7", "rca", rca, 16'h1234);
    chk(cid == CID2 && csd == CSDV, "R10", "cid/csd", cid ^ CID2, csd ^ CSDV);

    // R5 R3: sweep retry limit against busy count
    for (int l = 1; l <= 4; l++)
      for (int b = 0; b <= 4; b++) begin
        setup(b, l, b[0], 16'(16'h0100 + l * 16 + b), 16'h0, 1, 99, l[0], b < 2);
        run(ended);
        if (b < l) begin
          build_exp(b, l[0], b < 2, 16'(16'h0100 + l * 16 + b));
          cmp_seq("R3");
          chk(done && ccs == b[0], "R5", $sformatf("L%0d B%0d success", l, b),
              {done, ccs}, {1'b1, b[0]});
        end else begin
          chk(err_code == 3'd2 && count41() == 1 + l, "R5",
              $sformatf("L%0d B%0d retry abort code/polls", l, b),
              {err_code, 8'(count41())}, {3'd2, 8'(1 + l)});
        end
      end

    // R5: zero limit acts as one
    setup(1, 0, 0, 16'h0042, 16'h0, 1, 99, 0, 0);
    run(ended);
    chk(err_code == 3'd2 && count41() == 2, "R5", "limit 0", {err_code, 8'(count41())}, {3'd2, 8'd2});

    // R4
    setup(0, 8, 0, 16'h0042, 16'h0, 1, 41, 0, 0);
    run(ended); expect_err(1, "R4");

    // R1 after error: full warm-up again, restart clears error
    setup(0, 8, 0, 16'h0777, 16'h0, 1, 99, 0, 0);
    run(ended);
    chk(warm_cnt == WARM, "R1", "warm-up after error", warm_cnt, WARM);
    chk(done && !err && err_code == 0, "R11", "restart clears error", {done, err, err_code}, 5'b10000);
    build_exp(0, 0, 0, 16'h0777);
    cmp_seq("R6");

    // R7
    setup(0, 8, 0, 16'h0000, 16'h0, 1, 99, 0, 0);
    run(ended); expect_err(3, "R7");

    // R8
    setup(0, 8, 0, 16'h0055, 16'h0100, 1, 99, 1, 0);
    run(ended); expect_err(4, "R8");

    // R2: application prefix rejected
    setup(0, 8, 0, 16'h0055, 16'h0, 0, 99, 0, 0);
    run(ended); expect_err(5, "R2");
    chk(n_log == 2 && log_idx[1] == 55 && log_arg[1] == 0, "R2", "prefix with zero rca",
        {n_log[7:0], log_idx[1][7:0]}, {8'd2, 8'd55});

    // R9
    setup(0, 8, 0, 16'h0055, 16'h0, 1, 9, 0, 1);
    run(ended); expect_err(6, "R9");
    chk(log_idx[n_log-1] == 9, "R9", "last command before abort", log_idx[n_log-1], 9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule